// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is one level of direct-mapped, write-back cache placed between several requester ports and a fixed-latency backing store. Each requester presents a word or line read or write on its own port and holds the request until its done strobe appears. The cache serves one requester at a time. The first port that presents while the cache is idle becomes the owner and keeps the cache until its request completes. If several ports present together in that first cycle, the lowest-numbered port wins.

On a miss the controller drives its lower port with its own fixed requester ID. A dirty victim is first written back as a full line. The missing line is then read in. Both steps advance on the lower level's done strobe. While the line is absent the cache's own hit-latency countdown does not move. Once the line is resident, the countdown runs down from the configured hit delay and the request completes. Written data stays in the cache until the line is evicted.

Top module: `cache_wb_top`

## Requirements
- R1: A word address splits into a 2-bit word offset in bits [1:0], a line index in the next IDX_W bits, and a tag in the remaining upper bits. A word read returns word `offset` of the line, with word 0 in line bits [WORD_W-1:0]. A line access ignores the offset bits.
- R2: After reset every line is invalid and clean. No done strobe and no lower request appear while no port presents. The first access to any line misses.
- R3: A completed word write stores only the addressed word, and a completed line write replaces all four words. Either one marks the line dirty.
- R4: A request to a resident line asserts its done strobe on presentation HIT_DELAY+1, counting the presentation that hit as the first.
- R5: On a miss to a clean line, the cache issues a lower line read (`low_write`=0) at address {tag, index, 2'b00}. On the lower done strobe it fills the line and records the tag. With a lower level whose done comes on its own presentation D+1, a cold access completes on presentation D + HIT_DELAY + 2.
- R6: On a miss to a dirty line, the cache first issues a lower line write (`low_write`=1) of the victim line at {stored tag, index, 2'b00}. On that done strobe the line becomes clean, and the refill of R5 follows. The total is 2(D+1) + HIT_DELAY + 1 presentations.
- R7: While the addressed line is missing, the hit countdown holds its value. No done strobe is given in a cycle in which a lower request is driven.
- R8: The first port that presents while the cache is idle owns it until its done. A port presenting later, whatever its index, sees no done until then. Among ports first presenting in the same cycle, the lowest index wins.
- R9: At completion the countdown reloads and ownership is released. A waiting port whose line is now resident completes HIT_DELAY+1 presentations after it takes ownership.
- R10: A write hit is not passed to the lower level. The backing store changes only through a victim writeback.
- R11: Read data (`rd_word`, `rd_line`) is valid in the cycle the done strobe is high and reflects every earlier completed write.
- R12: Every lower request carries the fixed ID CACHE_ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Per-port request present |
| req_write | input | NREQ | Per-port 1 = write, 0 = read |
| req_line | input | NREQ | Per-port 1 = full line, 0 = single word |
| req_addr | input | NREQ x AW | Per-port word address |
| req_wword | input | NREQ x WORD_W | Per-port word write data |
| req_wline | input | NREQ x 4*WORD_W | Per-port line write data, word 0 in low bits |
| req_done | output | NREQ | Per-port completion strobe |
| rd_word | output | WORD_W | Addressed word of the owner's line |
| rd_line | output | 4*WORD_W | Owner's addressed line |
| low_req | output | 1 | Lower-level request present |
| low_id | output | IDW | Requester ID of the cache on the lower port |
| low_write | output | 1 | Lower request is a line write |
| low_addr | output | AW | Line-aligned lower address |
| low_wline | output | 4*WORD_W | Victim line for writeback |
| low_done | input | 1 | Lower-level completion strobe |
| low_rline | input | 4*WORD_W | Line returned by the lower level |

## Verification
Completion time depends on the line state. A resident line completes on presentation HIT_DELAY+1. A clean miss completes (D+1)+HIT_DELAY+1 presentations in, and a dirty miss 2(D+1)+HIT_DELAY+1. A waiting port completes HIT_DELAY+1 presentations after the owner's done. The bench keeps its own model of tags, dirty marks and expected contents, and predicts the exact presentation for each request. Inputs change one nanosecond after a rising edge, and the done strobe and read data are sampled at the falling edge of each presentation. The bench counts presentations up to the strobe and compares that count with the prediction. It reads the backing store it models itself to check the order, address and direction of lower transfers, and that write hits do not reach the store.

// File: rtl/cache_pkg.sv
// Shared constants and types for the write-back cache.
// Assumes four words per line, so the word offset is always two bits.
package cache_pkg;
    localparam int WORDS_PER_LINE = 4;
    localparam int OFFSET_W       = 2;

    typedef enum logic {
        LOWER_READ  = 1'b0,
        LOWER_WRITE = 1'b1
    } lower_op_e;
endpackage

// File: rtl/cache_owner_arb.sv
// First-come owner lock. When idle, the lowest-indexed presenting port is
// selected and latched as owner. The lock is held until release_i.
// Assumes release_i is only raised in a cycle where the owner presents.
module cache_owner_arb #(
    parameter int NREQ  = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req_valid,
    input  logic             release_i,
    output logic [SEL_W-1:0] sel_idx,
    output logic             sel_valid
);
    logic             busy_q;
    logic [SEL_W-1:0] own_q;
    logic [SEL_W-1:0] first_idx;

    // Lowest-indexed presenting port, used only while idle.
    always_comb begin
        first_idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req_valid[i]) first_idx = SEL_W'(i);
        end
    end

    // Current owner: the latched port when busy, otherwise the new claimant.
    always_comb begin
        sel_idx   = busy_q ? own_q : first_idx;
        sel_valid = req_valid[sel_idx];
    end

    // Take the lock on first presentation and drop it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            own_q  <= '0;
        end else if (release_i) begin
            busy_q <= 1'b0;
        end else if (!busy_q && sel_valid) begin
            busy_q <= 1'b1;
            own_q  <= first_idx;
        end
    end

    // R8
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !release_i) |=> (busy_q && own_q == $past(own_q)));

    // R9
    owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !busy_q);
endmodule

// File: rtl/cache_tag_store.sv
// Per-line tag, valid and dirty metadata for a direct-mapped array.
// After reset lines are invalid with all-ones tags and clean. Fill, clean
// and dirty updates arrive from separate controllers and never collide.
module cache_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill_en,
    input  logic             clean_en,
    input  logic             dirty_en,
    output logic             hit,
    output logic             victim_dirty,
    output logic [TAG_W-1:0] victim_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Lookup of the addressed line.
    always_comb begin
        hit          = valid_q[idx] && (tag_q[idx] == tag);
        victim_dirty = dirty_q[idx];
        victim_tag   = tag_q[idx];
    end

    // Metadata updates from refill, writeback and write completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                tag_q[idx]   <= tag;
                dirty_q[idx] <= 1'b0;
            end
            if (clean_en) dirty_q[idx] <= 1'b0;
            if (dirty_en) dirty_q[idx] <= 1'b1;
        end
    end

    // R5
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(idx)] && tag_q[$past(idx)] == $past(tag)));

    // R6
    wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_en |=> !dirty_q[$past(idx)]);

    // R2
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/cache_line_store.sv
// Data array of the cache, one line of four words per index.
// Fill, line write and word write are mutually exclusive in a cycle.
module cache_line_store #(
    parameter int IDX_W  = 2,
    parameter int WORD_W = 32,
    parameter int LINE_W = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx,
    input  logic [cache_pkg::OFFSET_W-1:0] off,
    input  logic                         wr_word_en,
    input  logic                         wr_line_en,
    input  logic                         fill_en,
    input  logic [WORD_W-1:0]            wword,
    input  logic [LINE_W-1:0]            wline,
    input  logic [LINE_W-1:0]            fill_line,
    output logic [LINE_W-1:0]            cur_line,
    output logic [WORD_W-1:0]            cur_word
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] data_q [LINES];

    // Read of the addressed line and word.
    always_comb begin
        cur_line = data_q[idx];
        cur_word = cur_line[int'(off) * WORD_W +: WORD_W];
    end

    // Line refill, line write or single-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) data_q[i] <= '0;
        end else if (fill_en) begin
            data_q[idx] <= fill_line;
        end else if (wr_line_en) begin
            data_q[idx] <= wline;
        end else if (wr_word_en) begin
            data_q[idx][int'(off) * WORD_W +: WORD_W] <= wword;
        end
    end

    // R7
    fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !(wr_word_en || wr_line_en));

    // R3
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word_en && !wr_line_en && !fill_en) |=>
            data_q[$past(idx)][int'($past(off)) * WORD_W +: WORD_W] == $past(wword));
endmodule

// File: rtl/cache_miss_ctrl.sv
// Miss sequencing toward the lower level. The phase comes from the victim's
// dirty mark: dirty means writeback of the victim, clean means refill of the
// missing line. Completion of either step is taken from low_done.
// Purely combinational; state lives in the tag store.
module cache_miss_ctrl #(
    parameter int AW       = 8,
    parameter int IDX_W    = 2,
    parameter int TAG_W    = 4,
    parameter int LINE_W   = 128,
    parameter int IDW      = 2,
    parameter int CACHE_ID = 3
) (
    input  logic              present,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic [TAG_W-1:0]  victim_tag,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic [LINE_W-1:0] victim_line,
    input  logic              low_done,
    output logic              low_req,
    output logic [IDW-1:0]    low_id,
    output logic              low_write,
    output logic [AW-1:0]     low_addr,
    output logic [LINE_W-1:0] low_wline,
    output logic              fill_en,
    output logic              clean_en
);
    import cache_pkg::*;

    lower_op_e op;

    // Choose writeback or refill and build the lower request.
    always_comb begin
        low_req   = present && !hit;
        op        = victim_dirty ? LOWER_WRITE : LOWER_READ;
        low_write = (op == LOWER_WRITE);
        low_id    = IDW'(CACHE_ID);
        low_wline = victim_line;
        if (op == LOWER_WRITE) low_addr = {victim_tag, idx, {OFFSET_W{1'b0}}};
        else                   low_addr = {tag, idx, {OFFSET_W{1'b0}}};
        fill_en   = low_req && low_done && (op == LOWER_READ);
        clean_en  = low_req && low_done && (op == LOWER_WRITE);
    end
endmodule

// File: rtl/cache_hit_timer.sv
// Hit-latency countdown. It moves only in cycles where the owner presents
// to a resident line. done is raised when it is zero, and it then reloads.
module cache_hit_timer #(
    parameter int HIT_DELAY = 2,
    parameter int CNT_W     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present_hit,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    // Completion when the countdown has run out.
    assign done = present_hit && (cnt_q == '0);

    // Decrement on each resident presentation, reload on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(HIT_DELAY);
        end else if (present_hit) begin
            cnt_q <= (cnt_q == '0) ? CNT_W'(HIT_DELAY) : cnt_q - 1'b1;
        end
    end

    // R7
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !present_hit |=> $stable(cnt_q));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cnt_q == CNT_W'(HIT_DELAY));
endmodule

// File: rtl/cache_wb_top.sv
// Direct-mapped write-back cache with an owner lock over NREQ ports and a
// lower-level line port. Word addressed, four words per line. Assumes the
// lower level holds low_done low unless low_req is high.
module cache_wb_top #(
    parameter int AW        = 8,
    parameter int IDX_W     = 2,
    parameter int WORD_W    = 32,
    parameter int NREQ      = 2,
    parameter int IDW       = 2,
    parameter int CACHE_ID  = 3,
    parameter int HIT_DELAY = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NREQ-1:0]                       req_valid,
    input  logic [NREQ-1:0]                       req_write,
    input  logic [NREQ-1:0]                       req_line,
    input  logic [NREQ-1:0][AW-1:0]               req_addr,
    input  logic [NREQ-1:0][WORD_W-1:0]           req_wword,
    input  logic [NREQ-1:0][4*WORD_W-1:0]         req_wline,
    output logic [NREQ-1:0]                       req_done,
    output logic [WORD_W-1:0]                     rd_word,
    output logic [4*WORD_W-1:0]                   rd_line,
    output logic                                  low_req,
    output logic [IDW-1:0]                        low_id,
    output logic                                  low_write,
    output logic [AW-1:0]                         low_addr,
    output logic [4*WORD_W-1:0]                   low_wline,
    input  logic                                  low_done,
    input  logic [4*WORD_W-1:0]                   low_rline
);
    import cache_pkg::*;

    localparam int LINE_W = WORDS_PER_LINE * WORD_W;
    localparam int TAG_W  = AW - IDX_W - OFFSET_W;
    localparam int SEL_W  = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int CNT_W  = $clog2(HIT_DELAY + 2);

    logic [SEL_W-1:0]    sel_idx;
    logic                sel_valid;
    logic [AW-1:0]       cur_addr;
    logic [TAG_W-1:0]    cur_tag;
    logic [IDX_W-1:0]    cur_idx;
    logic [OFFSET_W-1:0] cur_off;
    logic                hit;
    logic                victim_dirty;
    logic [TAG_W-1:0]    victim_tag;
    logic                fill_en;
    logic                clean_en;
    logic                hit_done;
    logic                wr_word_en;
    logic                wr_line_en;
    logic [LINE_W-1:0]   cur_line;

    // Owner selection and address split of the owner's request.
    always_comb begin
        cur_addr = req_addr[sel_idx];
        cur_off  = cur_addr[OFFSET_W-1:0];
        cur_idx  = cur_addr[OFFSET_W +: IDX_W];
        cur_tag  = cur_addr[AW-1 -: TAG_W];
    end

    cache_owner_arb #(.NREQ(NREQ), .SEL_W(SEL_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .release_i (hit_done),
        .sel_idx   (sel_idx),
        .sel_valid (sel_valid)
    );

    cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx          (cur_idx),
        .tag          (cur_tag),
        .fill_en      (fill_en),
        .clean_en     (clean_en),
        .dirty_en     (wr_word_en || wr_line_en),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .victim_tag   (victim_tag)
    );

    cache_miss_ctrl #(
        .AW(AW), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
        .IDW(IDW), .CACHE_ID(CACHE_ID)
    ) u_miss (
        .present      (sel_valid),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .victim_tag   (victim_tag),
        .idx          (cur_idx),
        .tag          (cur_tag),
        .victim_line  (cur_line),
        .low_done     (low_done),
        .low_req      (low_req),
        .low_id       (low_id),
        .low_write    (low_write),
        .low_addr     (low_addr),
        .low_wline    (low_wline),
        .fill_en      (fill_en),
        .clean_en     (clean_en)
    );

    cache_hit_timer #(.HIT_DELAY(HIT_DELAY), .CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .present_hit (sel_valid && hit),
        .done        (hit_done)
    );

    // Write enables at completion of the owner's request.
    always_comb begin
        wr_word_en = hit_done && req_write[sel_idx] && !req_line[sel_idx];
        wr_line_en = hit_done && req_write[sel_idx] &&  req_line[sel_idx];
    end

    cache_line_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (cur_idx),
        .off        (cur_off),
        .wr_word_en (wr_word_en),
        .wr_line_en (wr_line_en),
        .fill_en    (fill_en),
        .wword      (req_wword[sel_idx]),
        .wline      (req_wline[sel_idx]),
        .fill_line  (low_rline),
        .cur_line   (cur_line),
        .cur_word   (rd_word)
    );

    assign rd_line = cur_line;

    // Done strobe to the owning port only.
    always_comb begin
        req_done = '0;
        if (hit_done) req_done[sel_idx] = 1'b1;
    end

    // R8
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_done));

    // R8
    done_to_presenter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done & ~req_valid) == '0);

    // R7
    no_done_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_req |-> (req_done == '0));

    // R6
    wb_other_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_req && low_write) |-> (low_addr[AW-1 -: TAG_W] != cur_tag));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == '0) |-> (!low_req && req_done == '0));
endmodule

// File: tb/tb_cache_wb_top.sv
`timescale 1ns/1ps
module tb_cache_wb_top;
    localparam int AW = 8, IDX_W = 2, WORD_W = 32, NREQ = 2, IDW = 2;
    localparam int CID = 3, CD = 2, MD = 4;
    localparam int LAT_HIT   = CD + 1;
    localparam int LAT_CLEAN = (MD + 1) + CD + 1;
    localparam int LAT_DIRTY = 2 * (MD + 1) + CD + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0] req_valid = '0, req_write = '0, req_line = '0;
    logic [NREQ-1:0][AW-1:0] req_addr = '0;
    logic [NREQ-1:0][WORD_W-1:0] req_wword = '0;
    logic [NREQ-1:0][4*WORD_W-1:0] req_wline = '0;
    logic [NREQ-1:0] req_done;
    logic [WORD_W-1:0] rd_word;
    logic [4*WORD_W-1:0] rd_line;
    logic low_req, low_write, low_done;
    logic [IDW-1:0] low_id;
    logic [AW-1:0] low_addr;
    logic [4*WORD_W-1:0] low_wline, low_rline;

    always #2 clk = ~clk;

    cache_wb_top #(.AW(AW), .IDX_W(IDX_W), .WORD_W(WORD_W), .NREQ(NREQ),
                   .IDW(IDW), .CACHE_ID(CID), .HIT_DELAY(CD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_line(req_line), .req_addr(req_addr), .req_wword(req_wword),
        .req_wline(req_wline), .req_done(req_done), .rd_word(rd_word),
        .rd_line(rd_line), .low_req(low_req), .low_id(low_id),
        .low_write(low_write), .low_addr(low_addr), .low_wline(low_wline),
        .low_done(low_done), .low_rline(low_rline)
    );

    function automatic logic [31:0] pat(input int a);
        return 32'hA500_0000 | (32'(a) << 8) | 32'((~a) & 8'hFF);
    endfunction

    // Backing store model: fixed delay, first-come owner lock on ID.
    logic [31:0] mem_w [256];
    logic [2:0]  mwait;
    logic        mown_busy;
    logic [IDW-1:0] mown_id;
    logic [AW-1:0] log_addr [32];
    logic        log_wr [32];
    int          log_n;
    logic        bad_id;
    logic [7:0]  mbase;

    assign mbase     = {low_addr[7:2], 2'b00};
    assign low_done  = low_req && (!mown_busy || mown_id == low_id) && mwait == 3'd0;
    assign low_rline = {mem_w[mbase + 8'd3], mem_w[mbase + 8'd2], mem_w[mbase + 8'd1], mem_w[mbase]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem_w[a] <= pat(a);
            mwait <= 3'(MD); mown_busy <= 1'b0; mown_id <= '0;
            log_n <= 0; bad_id <= 1'b0;
        end else if (low_req) begin
            if (low_id != IDW'(CID)) bad_id <= 1'b1;
            if (!mown_busy || mown_id == low_id) begin
                if (mwait == 3'd0) begin
                    mwait <= 3'(MD); mown_busy <= 1'b0;
                    if (low_write)
                        for (int w = 0; w < 4; w++) mem_w[mbase + 8'(w)] <= low_wline[w*32 +: 32];
                    log_addr[log_n % 32] <= low_addr;
                    log_wr[log_n % 32]   <= low_write;
                    log_n <= log_n + 1;
                end else begin
                    mwait <= mwait - 3'd1; mown_busy <= 1'b1; mown_id <= low_id;
                end
            end
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;
    int wd = 0;

    // Bench model of cache state and of expected memory contents.
    bit mvalid [4];
    logic [3:0] mtag [4];
    bit mdirty [4];
    logic [31:0] shadow [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] shadow_line(input logic [7:0] a);
        logic [7:0] b = {a[7:2], 2'b00};
        return {shadow[b + 8'd3], shadow[b + 8'd2], shadow[b + 8'd1], shadow[b]};
    endfunction

    task automatic do_op(input int p, input bit wr, input bit ln, input logic [7:0] a,
                         input logic [31:0] ww, input logic [127:0] wl, input string req);
        int idx = int'(a[3:2]);
        bit hit = mvalid[idx] && mtag[idx] == a[7:4];
        int lat = hit ? LAT_HIT : (mdirty[idx] ? LAT_DIRTY : LAT_CLEAN);
        int c = 0;
        bit got = 0;
        logic [31:0] w_s = '0;
        logic [127:0] l_s = '0;
        @(posedge clk); #1;
        req_write[p] = wr; req_line[p] = ln; req_addr[p] = a;
        req_wword[p] = ww; req_wline[p] = wl; req_valid[p] = 1'b1;
        while (!got && c < 60) begin
            @(negedge clk); c++;
            if (req_done[p]) begin got = 1; w_s = rd_word; l_s = rd_line; end
            else begin @(posedge clk); #1; end
        end
        @(posedge clk); #1; req_valid[p] = 1'b0;
        chk(c == lat, req, "latency", 128'(c), 128'(lat));
        if (!wr) begin
            if (ln) chk(l_s == shadow_line(a), req, "line data", l_s, shadow_line(a));
            else    chk(w_s == shadow[a], req, "word data", 128'(w_s), 128'(shadow[a]));
        end
        if (!hit) begin mvalid[idx] = 1; mtag[idx] = a[7:4]; mdirty[idx] = 0; end
        if (wr) begin
            mdirty[idx] = 1;
            if (ln) for (int w = 0; w < 4; w++) shadow[{a[7:2], 2'(w)}] = wl[w*32 +: 32];
            else shadow[a] = ww;
        end
    endtask

    // Two concurrent reads; each port joins on its own presentation number.
    task automatic two_port(input logic [7:0] a0, input logic [7:0] a1,
                            input int j0, input int j1, output int d0, output int d1,
                            output logic [31:0] w0, output logic [31:0] w1);
        bit f0 = 0, f1 = 0;
        d0 = 0; d1 = 0; w0 = '0; w1 = '0;
        req_write = '0; req_line = '0;
        req_addr[0] = a0; req_addr[1] = a1;
        for (int c = 1; c <= 60 && !(f0 && f1); c++) begin
            @(posedge clk); #1;
            req_valid[0] = (c >= j0) && !f0;
            req_valid[1] = (c >= j1) && !f1;
            @(negedge clk);
            if (req_done[0]) begin f0 = 1; d0 = c; w0 = rd_word; end
            if (req_done[1]) begin f1 = 1; d1 = c; w1 = rd_word; end
        end
        @(posedge clk); #1; req_valid = '0;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, d0, d1;
        logic [31:0] w0, w1;
        logic [127:0] lw;
        for (int a = 0; a < 256; a++) shadow[a] = pat(a);
        for (int i = 0; i < 4; i++) begin mvalid[i] = 0; mtag[i] = '0; mdirty[i] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: quiet after reset with no presenter
        @(negedge clk);
        chk(req_done == '0, "R2", "done after reset", 128'(req_done), 0);
        chk(!low_req, "R2", "lower request after reset", 128'(low_req), 0);

        // R5: cold write to a clean line goes through one lower read
        n0 = log_n;
        do_op(0, 1, 0, 8'h00, 32'h1122_3344, '0, "R5");
        chk(log_n == n0 + 1, "R5", "lower op count", 128'(log_n - n0), 1);
        chk(!log_wr[n0 % 32] && log_addr[n0 % 32] == 8'h00, "R5", "refill read addr",
            128'({log_wr[n0 % 32], log_addr[n0 % 32]}), 0);
        // R10: no write-through
        chk(mem_w[0] == pat(0), "R10", "store after write hit", 128'(mem_w[0]), 128'(pat(0)));

        // R4/R3: hit read back of written word; R9 other port on resident line
        do_op(0, 0, 0, 8'h00, '0, '0, "R4");
        do_op(1, 0, 0, 8'h01, '0, '0, "R9");

        // R6/R7: conflicting tag on a dirty line: writeback then refill
        n0 = log_n;
        do_op(0, 1, 0, 8'h42, 32'hCAFE_F00D, '0, "R6");
        chk(log_n == n0 + 2, "R6", "lower op count", 128'(log_n - n0), 2);
        chk(log_wr[n0 % 32] && log_addr[n0 % 32] == 8'h00, "R6", "writeback first",
            128'({log_wr[n0 % 32], log_addr[n0 % 32]}), 128'({1'b1, 8'h00}));
        chk(!log_wr[(n0 + 1) % 32] && log_addr[(n0 + 1) % 32] == 8'h40, "R6", "refill second",
            128'({log_wr[(n0 + 1) % 32], log_addr[(n0 + 1) % 32]}), 128'({1'b0, 8'h40}));
        chk(mem_w[0] == 32'h1122_3344, "R6", "victim word in store", 128'(mem_w[0]), 128'h1122_3344);
        chk(mem_w[8'h42] == pat(8'h42), "R10", "no write-through", 128'(mem_w[8'h42]), 128'(pat(8'h42)));

        // R8/R9: simultaneous cold reads, same line, lower index wins
        two_port(8'h14, 8'h15, 1, 1, d0, d1, w0, w1);
        chk(d0 == LAT_CLEAN, "R8", "port0 done", 128'(d0), 128'(LAT_CLEAN));
        chk(d1 == LAT_CLEAN + CD + 1, "R9", "port1 done", 128'(d1), 128'(LAT_CLEAN + CD + 1));
        chk(w0 == shadow[8'h14] && w1 == shadow[8'h15], "R11", "two-port data",
            128'({w0, w1}), 128'({shadow[8'h14], shadow[8'h15]}));
        mvalid[1] = 1; mtag[1] = 4'h1; mdirty[1] = 0;

        // R8: earlier presenter keeps ownership over a lower index
        two_port(8'h19, 8'h18, 2, 1, d0, d1, w0, w1);
        chk(d1 == LAT_CLEAN, "R8", "first-come port1 done", 128'(d1), 128'(LAT_CLEAN));
        chk(d0 == LAT_CLEAN + CD + 1, "R8", "late port0 done", 128'(d0), 128'(LAT_CLEAN + CD + 1));
        chk(w0 == shadow[8'h19] && w1 == shadow[8'h18], "R11", "first-come data",
            128'({w0, w1}), 128'({shadow[8'h19], shadow[8'h18]}));
        mvalid[2] = 1; mtag[2] = 4'h1; mdirty[2] = 0;

        // R3/R1: line write, line read at another offset, single word
        lw = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};
        do_op(0, 1, 1, 8'h2C, '0, lw, "R3");
        do_op(1, 0, 1, 8'h2E, '0, '0, "R3");
        do_op(0, 0, 0, 8'h2D, '0, '0, "R1");

        // R11/R1: sweep of mixed accesses over four tags and all lines
        for (int s = 0; s < 80; s++) begin
            logic [7:0] a = 8'((s * 37 + 5) & 8'h3F);
            do_op(s % 2, (s % 3) == 1, (s % 4) == 2, a, 32'h7000_0000 + 32'(s),
                  {4{32'h0BAD_0000 + 32'(s)}}, "R11");
        end

        // R12: every lower request carried the cache ID
        chk(!bad_id, "R12", "lower id", 128'(bad_id), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule